// File: doc/BRIEF.md
# Multi-Size Address Translation Cache

This block keeps a small fully associative set of recent virtual-to-physical page translations and sits in front of a page table walker. Every translation request probes it first. When a valid entry matches both the page number and the current address space identifier, the block reports a hit and the physical address in the same cycle, so no walk is needed. When nothing matches, it asks the walker for a translation. When the walker answers on the fill port, the result is written into an entry.

Each entry records the size of the page it maps: 4 KiB, 2 MiB or 1 GiB. That size decides how many low page-number bits are left out of the tag compare and copied straight from the virtual address into the physical address. One entry can therefore cover a much larger region. A flush input invalidates either every entry or only the entries of one address space.

Top module: `xlat_buffer`

## Requirements
- R1: After reset every entry is invalid. A lookup misses, and the walk request output is low.
- R2: A 4 KiB entry (size code 0) hits only when all virtual page-number bits match. The physical address is the entry's frame number followed by virtual address bits 11:0, in the same cycle as the lookup.
- R3: A 2 MiB entry (size code 1) leaves virtual address bits 20:12 out of the compare. The physical address takes frame-number bits above bit 8 and virtual address bits 20:0.
- R4: A 1 GiB entry (size code 2) leaves virtual address bits 29:12 out of the compare. The physical address takes frame-number bits above bit 17 and virtual address bits 29:0.
- R5: A lookup hits only when the entry's address space identifier equals the lookup's identifier.
- R6: A valid lookup that misses while no walk is outstanding raises walk_req for exactly one cycle, on the next cycle. It carries that lookup's address and identifier. No further request is raised until a fill arrives.
- R7: A fill installs its translation, and a lookup in the following cycle hits it. A fill also ends the outstanding walk.
- R8: A fill takes the lowest-numbered invalid entry, so a fill evicts nothing while a free entry exists. When all entries are valid, a round-robin pointer picks the victim. The pointer starts at entry 0 and advances by one on each such fill.
- R9: A flush with flush_all set invalidates every entry.
- R10: A flush with flush_all clear invalidates only the entries whose identifier equals flush_asid. All other entries keep hitting.
- R11: A fill presented in the same cycle as a flush is discarded.
- R12: With lkp_valid low, lkp_hit stays low and no walk is requested.
- R13: Size code 3 is treated as a 4 KiB page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lkp_valid | input | 1 | Lookup request this cycle |
| lkp_vaddr | input | VA_W | Virtual address to translate |
| lkp_asid | input | ASID_W | Current address space identifier |
| lkp_hit | output | 1 | Lookup matched an entry |
| lkp_paddr | output | PA_W | Translated physical address (valid with lkp_hit) |
| walk_req | output | 1 | One-cycle request to the walker |
| walk_vaddr | output | VA_W | Address that missed |
| walk_asid | output | ASID_W | Identifier of the missing lookup |
| fill_valid | input | 1 | Walker returns a translation |
| fill_vpn | input | VA_W-12 | Virtual page number of the fill |
| fill_asid | input | ASID_W | Identifier of the fill |
| fill_ppn | input | PA_W-12 | Physical frame number of the fill |
| fill_size | input | 2 | Page size code: 0 4 KiB, 1 2 MiB, 2 1 GiB, 3 as 4 KiB |
| flush_valid | input | 1 | Invalidate request |
| flush_all | input | 1 | Invalidate every entry instead of one identifier |
| flush_asid | input | ASID_W | Identifier to invalidate |

## Verification
Lookups are tried at the first and last offsets inside each page size, and at the neighbouring page just outside it. A wrong compare mask is caught as a false hit or a false miss, and a wrong merge shows up as a bad physical address. Frame numbers whose low bits are not zero show that the large-page merge drops those bits. The same address with another identifier, the size code 3 case and the two flush forms separate the identifier logic from the size logic. A fill-all-then-partial-flush sequence separates "prefer a free entry" from plain round-robin replacement.

// File: rtl/xb_pkg.sv
`timescale 1ns/1ps
package xb_pkg;

    localparam int OFS_W  = 12;
    localparam int LVL_W  = 9;
    localparam int SPAN_W = 2 * LVL_W;

    typedef enum logic [1:0] {
        PG_4K  = 2'd0,
        PG_2M  = 2'd1,
        PG_1G  = 2'd2,
        PG_RSV = 2'd3
    } pg_size_e;

    // Low page-number bits that take part in the compare and come from the frame.
    function automatic logic [SPAN_W-1:0] span_keep(input pg_size_e sz);
        case (sz)
            PG_2M:   return {{LVL_W{1'b1}}, {LVL_W{1'b0}}};
            PG_1G:   return '0;
            default: return '1;
        endcase
    endfunction

    function automatic logic [SPAN_W-1:0] merge_span(
        input logic [SPAN_W-1:0] frame_lo,
        input logic [SPAN_W-1:0] page_lo,
        input logic [SPAN_W-1:0] keep
    );
        return (frame_lo & keep) | (page_lo & ~keep);
    endfunction

endpackage

// File: rtl/xb_slot.sv
`timescale 1ns/1ps
module xb_slot
    import xb_pkg::*;
#(
    parameter int VPN_W  = 27,
    parameter int PPN_W  = 28,
    parameter int ASID_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [PPN_W-1:0]  wr_ppn,
    input  pg_size_e          wr_size,
    input  logic              flush_valid,
    input  logic              flush_all,
    input  logic [ASID_W-1:0] flush_asid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              valid,
    output logic              match,
    output logic [PPN_W-1:0]  ppn,
    output pg_size_e          size
);

    logic              valid_q;
    logic [VPN_W-1:0]  vpn_q;
    logic [ASID_W-1:0] asid_q;
    logic [PPN_W-1:0]  ppn_q;
    pg_size_e          size_q;
    logic              drop;
    logic [VPN_W-1:0]  keep_full;

    assign drop = flush_valid && (flush_all || (asid_q == flush_asid));

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            vpn_q   <= '0;
            asid_q  <= '0;
            ppn_q   <= '0;
            size_q  <= PG_4K;
        end else if (drop) begin
            valid_q <= 1'b0;
        end else if (wr_en) begin
            valid_q <= 1'b1;
            vpn_q   <= wr_vpn;
            asid_q  <= wr_asid;
            ppn_q   <= wr_ppn;
            size_q  <= wr_size;
        end
    end

    assign keep_full = {{(VPN_W-SPAN_W){1'b1}}, span_keep(size_q)};
    assign match     = valid_q && (asid_q == lk_asid) && (((vpn_q ^ lk_vpn) & keep_full) == '0);
    assign valid     = valid_q;
    assign ppn       = ppn_q;
    assign size      = size_q;

endmodule

// File: rtl/xb_victim.sv
`timescale 1ns/1ps
module xb_victim #(
    parameter int N = 16,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     valid_vec,
    input  logic             take,
    output logic [IDX_W-1:0] idx
);

    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] free_idx;
    logic             any_free;

    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                any_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    assign idx = any_free ? free_idx : ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (take && !any_free) begin
            ptr_q <= (ptr_q == IDX_W'(N - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

endmodule

// File: rtl/xb_walk_ctl.sv
`timescale 1ns/1ps
module xb_walk_ctl #(
    parameter int VA_W   = 39,
    parameter int ASID_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              miss,
    input  logic [VA_W-1:0]   miss_vaddr,
    input  logic [ASID_W-1:0] miss_asid,
    input  logic              fill_seen,
    output logic              walk_req,
    output logic [VA_W-1:0]   walk_vaddr,
    output logic [ASID_W-1:0] walk_asid
);

    logic busy_q;
    logic issue;

    assign issue = miss && !busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q     <= 1'b0;
            walk_req   <= 1'b0;
            walk_vaddr <= '0;
            walk_asid  <= '0;
        end else begin
            walk_req <= issue;
            if (issue) begin
                busy_q     <= 1'b1;
                walk_vaddr <= miss_vaddr;
                walk_asid  <= miss_asid;
            end else if (fill_seen) begin
                busy_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/xlat_buffer.sv
`timescale 1ns/1ps
module xlat_buffer
    import xb_pkg::*;
#(
    parameter int VA_W    = 39,
    parameter int PA_W    = 40,
    parameter int ASID_W  = 8,
    parameter int ENTRIES = 16,
    localparam int VPN_W  = VA_W - OFS_W,
    localparam int PPN_W  = PA_W - OFS_W,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lkp_valid,
    input  logic [VA_W-1:0]   lkp_vaddr,
    input  logic [ASID_W-1:0] lkp_asid,
    output logic              lkp_hit,
    output logic [PA_W-1:0]   lkp_paddr,
    output logic              walk_req,
    output logic [VA_W-1:0]   walk_vaddr,
    output logic [ASID_W-1:0] walk_asid,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic [1:0]        fill_size,
    input  logic              flush_valid,
    input  logic              flush_all,
    input  logic [ASID_W-1:0] flush_asid
);

    logic [ENTRIES-1:0] slot_valid;
    logic [ENTRIES-1:0] slot_match;
    logic [PPN_W-1:0]   slot_ppn  [ENTRIES];
    pg_size_e           slot_size [ENTRIES];

    logic [VPN_W-1:0]   lk_vpn;
    logic               fill_take;
    logic [IDX_W-1:0]   victim;

    logic               any_match;
    logic [PPN_W-1:0]   sel_ppn;
    pg_size_e           sel_size;
    logic [SPAN_W-1:0]  sel_keep;
    logic [PPN_W-1:0]   out_pn;

    assign lk_vpn    = lkp_vaddr[VA_W-1:OFS_W];
    assign fill_take = fill_valid && !flush_valid;

    xb_victim #(.N(ENTRIES)) u_victim (
        .clk       (clk),
        .rst       (rst),
        .valid_vec (slot_valid),
        .take      (fill_take),
        .idx       (victim)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        xb_slot #(
            .VPN_W  (VPN_W),
            .PPN_W  (PPN_W),
            .ASID_W (ASID_W)
        ) u_slot (
            .clk         (clk),
            .rst         (rst),
            .wr_en       (fill_take && (victim == IDX_W'(g))),
            .wr_vpn      (fill_vpn),
            .wr_asid     (fill_asid),
            .wr_ppn      (fill_ppn),
            .wr_size     (pg_size_e'(fill_size)),
            .flush_valid (flush_valid),
            .flush_all   (flush_all),
            .flush_asid  (flush_asid),
            .lk_vpn      (lk_vpn),
            .lk_asid     (lkp_asid),
            .valid       (slot_valid[g]),
            .match       (slot_match[g]),
            .ppn         (slot_ppn[g]),
            .size        (slot_size[g])
        );
    end

    // Lowest-numbered matching entry wins.
    always_comb begin
        any_match = 1'b0;
        sel_ppn   = '0;
        sel_size  = PG_4K;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (slot_match[i]) begin
                any_match = 1'b1;
                sel_ppn   = slot_ppn[i];
                sel_size  = slot_size[i];
            end
        end
    end

    assign sel_keep  = span_keep(sel_size);
    assign out_pn    = {sel_ppn[PPN_W-1:SPAN_W],
                        merge_span(sel_ppn[SPAN_W-1:0], lk_vpn[SPAN_W-1:0], sel_keep)};
    assign lkp_hit   = lkp_valid && any_match;
    assign lkp_paddr = lkp_hit ? {out_pn, lkp_vaddr[OFS_W-1:0]} : '0;

    xb_walk_ctl #(
        .VA_W   (VA_W),
        .ASID_W (ASID_W)
    ) u_walk (
        .clk        (clk),
        .rst        (rst),
        .miss       (lkp_valid && !any_match),
        .miss_vaddr (lkp_vaddr),
        .miss_asid  (lkp_asid),
        .fill_seen  (fill_valid),
        .walk_req   (walk_req),
        .walk_vaddr (walk_vaddr),
        .walk_asid  (walk_asid)
    );

endmodule

// File: rtl/xlat_buffer_chk.sv
`timescale 1ns/1ps
module xlat_buffer_chk #(
    parameter int VA_W   = 39,
    parameter int PA_W   = 40,
    parameter int ASID_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              lkp_valid,
    input logic [VA_W-1:0]   lkp_vaddr,
    input logic [ASID_W-1:0] lkp_asid,
    input logic              lkp_hit,
    input logic [PA_W-1:0]   lkp_paddr,
    input logic              walk_req,
    input logic [VA_W-1:0]   walk_vaddr,
    input logic [ASID_W-1:0] walk_asid,
    input logic              fill_valid,
    input logic [VA_W-13:0]  fill_vpn,
    input logic [ASID_W-1:0] fill_asid,
    input logic              flush_valid,
    input logic              flush_all
);

    p_reset_clean_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!lkp_hit && !walk_req));

    p_offset_pass_r2: assert property (@(posedge clk) disable iff (rst)
        lkp_hit |-> (lkp_paddr[11:0] == lkp_vaddr[11:0]));

    p_walk_source_r6: assert property (@(posedge clk) disable iff (rst)
        walk_req |-> ($past(lkp_valid && !lkp_hit)
                      && walk_vaddr == $past(lkp_vaddr)
                      && walk_asid == $past(lkp_asid)));

    p_walk_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        walk_req |=> !walk_req);

    p_fill_visible_r7: assert property (@(posedge clk) disable iff (rst)
        (lkp_valid && $past(fill_valid && !flush_valid)
         && lkp_vaddr[VA_W-1:12] == $past(fill_vpn)
         && lkp_asid == $past(fill_asid)) |-> lkp_hit);

    p_flush_empty_r9: assert property (@(posedge clk) disable iff (rst)
        (flush_valid && flush_all) |=> !lkp_hit);

    p_hit_qualified_r12: assert property (@(posedge clk) disable iff (rst)
        lkp_hit |-> lkp_valid);

endmodule

bind xlat_buffer xlat_buffer_chk #(
    .VA_W   (VA_W),
    .PA_W   (PA_W),
    .ASID_W (ASID_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .lkp_valid   (lkp_valid),
    .lkp_vaddr   (lkp_vaddr),
    .lkp_asid    (lkp_asid),
    .lkp_hit     (lkp_hit),
    .lkp_paddr   (lkp_paddr),
    .walk_req    (walk_req),
    .walk_vaddr  (walk_vaddr),
    .walk_asid   (walk_asid),
    .fill_valid  (fill_valid),
    .fill_vpn    (fill_vpn),
    .fill_asid   (fill_asid),
    .flush_valid (flush_valid),
    .flush_all   (flush_all)
);

// File: tb/sim_xlat_buffer.sv
`timescale 1ns/1ps
module sim_xlat_buffer;

    localparam int VA_W = 39;
    localparam int PA_W = 40;
    localparam int AW   = 8;

    typedef struct packed {
        logic [1:0]  op;    // 0 lookup, 1 fill, 2 flush
        logic        all;
        logic [7:0]  asid;
        logic [1:0]  sz;
        logic [38:0] va;
        logic [27:0] ppn;
        logic        hit;
        logic [39:0] pa;
        logic [3:0]  rq;
    } vec_t;

    function automatic vec_t mk(input logic [1:0] op, input logic all, input logic [7:0] asid,
                                input logic [1:0] sz, input logic [38:0] va, input logic [27:0] ppn,
                                input logic hit, input logic [39:0] pa, input logic [3:0] rq);
        return '{op, all, asid, sz, va, ppn, hit, pa, rq};
    endfunction

    localparam int NV = 21;
    localparam vec_t TBL [NV] = '{
        mk(1, 0, 1, 0, 39'h0012345000, 28'h00ABCDE, 0, 40'h0, 7),          // R7
        mk(0, 0, 1, 0, 39'h0012345678, 28'h0, 1, 40'h00ABCDE678, 2),        // R2
        mk(0, 0, 2, 0, 39'h0012345678, 28'h0, 0, 40'h0, 5),                 // R5
        mk(0, 0, 1, 0, 39'h0012346678, 28'h0, 0, 40'h0, 2),                 // R2
        mk(1, 0, 1, 1, 39'h0080600000, 28'h0123400, 0, 40'h0, 7),           // R7
        mk(0, 0, 1, 0, 39'h008077ABCD, 28'h0, 1, 40'h012357ABCD, 3),        // R3
        mk(0, 0, 1, 0, 39'h0080600000, 28'h0, 1, 40'h0123400000, 3),        // R3
        mk(0, 0, 1, 0, 39'h0080800000, 28'h0, 0, 40'h0, 3),                 // R3
        mk(1, 0, 1, 2, 39'h0C40000000, 28'h7654321, 0, 40'h0, 7),           // R7
        mk(0, 0, 1, 0, 39'h0C7FFFF123, 28'h0, 1, 40'h767FFFF123, 4),        // R4
        mk(0, 0, 1, 0, 39'h0C3FFFF000, 28'h0, 0, 40'h0, 4),                 // R4
        mk(0, 0, 4, 0, 39'h0C40000000, 28'h0, 0, 40'h0, 5),                 // R5
        mk(1, 0, 3, 3, 39'h0000002000, 28'h0000055, 0, 40'h0, 7),           // R7
        mk(0, 0, 3, 0, 39'h0000002ABC, 28'h0, 1, 40'h0000055ABC, 13),       // R13
        mk(0, 0, 3, 0, 39'h0000003ABC, 28'h0, 0, 40'h0, 13),                // R13
        mk(2, 0, 1, 0, 39'h0, 28'h0, 0, 40'h0, 10),                         // R10
        mk(0, 0, 1, 0, 39'h0012345678, 28'h0, 0, 40'h0, 10),                // R10
        mk(0, 0, 1, 0, 39'h008077ABCD, 28'h0, 0, 40'h0, 10),                // R10
        mk(0, 0, 3, 0, 39'h0000002ABC, 28'h0, 1, 40'h0000055ABC, 10),       // R10
        mk(2, 1, 0, 0, 39'h0, 28'h0, 0, 40'h0, 9),                          // R9
        mk(0, 0, 3, 0, 39'h0000002ABC, 28'h0, 0, 40'h0, 9)                  // R9
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            lkp_valid = 1'b0;
    logic [VA_W-1:0] lkp_vaddr = '0;
    logic [AW-1:0]   lkp_asid = '0;
    logic            lkp_hit;
    logic [PA_W-1:0] lkp_paddr;
    logic            walk_req;
    logic [VA_W-1:0] walk_vaddr;
    logic [AW-1:0]   walk_asid;
    logic            fill_valid = 1'b0;
    logic [26:0]     fill_vpn = '0;
    logic [AW-1:0]   fill_asid = '0;
    logic [27:0]     fill_ppn = '0;
    logic [1:0]      fill_size = '0;
    logic            flush_valid = 1'b0;
    logic            flush_all = 1'b0;
    logic [AW-1:0]   flush_asid = '0;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    xlat_buffer u0 (
        .clk(clk), .rst(rst),
        .lkp_valid(lkp_valid), .lkp_vaddr(lkp_vaddr), .lkp_asid(lkp_asid),
        .lkp_hit(lkp_hit), .lkp_paddr(lkp_paddr),
        .walk_req(walk_req), .walk_vaddr(walk_vaddr), .walk_asid(walk_asid),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
        .fill_ppn(fill_ppn), .fill_size(fill_size),
        .flush_valid(flush_valid), .flush_all(flush_all), .flush_asid(flush_asid)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic t_fill(input logic [38:0] va, input logic [7:0] asid,
                          input logic [27:0] ppn, input logic [1:0] sz);
        fill_valid = 1'b1; fill_vpn = va[38:12]; fill_asid = asid;
        fill_ppn = ppn; fill_size = sz;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic t_flush(input logic all, input logic [7:0] asid);
        flush_valid = 1'b1; flush_all = all; flush_asid = asid;
        @(negedge clk);
        flush_valid = 1'b0; flush_all = 1'b0;
    endtask

    task automatic t_look(input logic [38:0] va, input logic [7:0] asid, input logic hit,
                          input logic [39:0] pa, input string rq);
        lkp_valid = 1'b1; lkp_vaddr = va; lkp_asid = asid;
        #1;
        chk(lkp_hit == hit, rq, "hit", 64'(lkp_hit), 64'(hit));
        if (hit) chk(lkp_paddr == pa, rq, "paddr", 64'(lkp_paddr), 64'(pa));
        @(negedge clk);
        lkp_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: empty after reset
        lkp_valid = 1'b1; lkp_vaddr = 39'h0012345678; lkp_asid = 8'd1;
        #1;
        chk(lkp_hit == 1'b0, "R1", "hit after reset", 64'(lkp_hit), 64'd0);
        chk(walk_req == 1'b0, "R1", "walk_req after reset", 64'(walk_req), 64'd0);
        lkp_valid = 1'b0;
        @(negedge clk);

        // R12: an idle lookup port neither hits nor requests a walk
        t_fill(39'h0000009000, 8'd2, 28'h0000111, 2'd0);
        lkp_vaddr = 39'h0000009123; lkp_asid = 8'd2;
        #1;
        chk(lkp_hit == 1'b0, "R12", "hit with lkp_valid low", 64'(lkp_hit), 64'd0);
        lkp_vaddr = 39'h0000ABC000;
        @(negedge clk);
        chk(walk_req == 1'b0, "R12", "walk_req with lkp_valid low", 64'(walk_req), 64'd0);

        // Vector table: sizes, identifiers and flush forms
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = TBL[i];
            case (v.op)
                2'd1:    t_fill(v.va, v.asid, v.ppn, v.sz);
                2'd2:    t_flush(v.all, v.asid);
                default: t_look(v.va, v.asid, v.hit, v.pa, $sformatf("R%0d", v.rq));
            endcase
        end

        // R6 / R7: walk request and fill handshake
        t_fill(39'h0000007000, 8'd6, 28'h0000007, 2'd0);
        t_flush(1'b1, 8'd0);
        lkp_valid = 1'b1; lkp_vaddr = 39'h0055555000; lkp_asid = 8'd5;
        #1;
        chk(lkp_hit == 1'b0, "R6", "miss before walk", 64'(lkp_hit), 64'd0);
        @(negedge clk);
        chk(walk_req == 1'b1, "R6", "walk_req after miss", 64'(walk_req), 64'd1);
        chk(walk_vaddr == 39'h0055555000, "R6", "walk_vaddr", 64'(walk_vaddr), 64'h0055555000);
        chk(walk_asid == 8'd5, "R6", "walk_asid", 64'(walk_asid), 64'd5);
        @(negedge clk);
        chk(walk_req == 1'b0, "R6", "no repeat while outstanding", 64'(walk_req), 64'd0);
        lkp_valid = 1'b0;
        t_fill(39'h0055555000, 8'd5, 28'h0000999, 2'd0);
        t_look(39'h0055555123, 8'd5, 1'b1, 40'h0000999123, "R7");
        t_look(39'h0066666000, 8'd5, 1'b0, 40'h0, "R6");
        chk(walk_req == 1'b1, "R6", "new walk after fill", 64'(walk_req), 64'd1);

        // R11: fill coinciding with a flush is dropped
        fill_valid = 1'b1; fill_vpn = 27'h0077777; fill_asid = 8'd5;
        fill_ppn = 28'h0000777; fill_size = 2'd0;
        flush_valid = 1'b1; flush_all = 1'b0; flush_asid = 8'h20;
        @(negedge clk);
        fill_valid = 1'b0; flush_valid = 1'b0;
        t_look(39'h0077777000, 8'd5, 1'b0, 40'h0, "R11");
        t_look(39'h0055555000, 8'd5, 1'b1, 40'h0000999000, "R10");

        // R8: free entries first, then round robin from entry 0
        t_flush(1'b1, 8'd0);
        for (int i = 0; i < 16; i++)
            t_fill(39'(i) << 12, (i % 2 == 0) ? 8'd7 : 8'd8, 28'(i), 2'd0);
        t_flush(1'b0, 8'd8);
        for (int k = 0; k < 8; k++)
            t_fill(39'(256 + k) << 12, 8'd9, 28'(256 + k), 2'd0);
        for (int i = 0; i < 16; i += 2)
            t_look(39'(i) << 12, 8'd7, 1'b1, 40'(i) << 12, "R8");
        for (int k = 0; k < 8; k++)
            t_look(39'(256 + k) << 12, 8'd9, 1'b1, 40'(256 + k) << 12, "R8");
        t_fill(39'h0000200000, 8'd9, 28'h0000200, 2'd0);
        t_look(39'h0000000000, 8'd7, 1'b0, 40'h0, "R8");
        t_look(39'h0000002000, 8'd7, 1'b1, 40'h0000002000, "R8");
        t_look(39'h0000200000, 8'd9, 1'b1, 40'h0000200000, "R8");
        t_fill(39'h0000201000, 8'd9, 28'h0000201, 2'd0);
        t_look(39'h0000100000, 8'd9, 1'b0, 40'h0, "R8");
        t_look(39'h0000101000, 8'd9, 1'b1, 40'h0000101000, "R8");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule